// File: doc/BRIEF.md
# Port-Based VLAN Egress Filter

This block decides, for each frame arriving on an ingress port, which ports of a small switch (six by default) may transmit it. A lookup stage presents the ingress port number and a candidate destination mask. One cycle later the block returns the permitted egress mask. A destination survives only if three things hold: the lookup offered it, the ingress port's membership map allows it, and the destination is in the forwarding state. The block returns the ingress port's default VLAN identifier and priority with the same response, so a later stage can tag untagged traffic.

Each port has three configuration registers, written through a simple write strobe: a control register carrying the 2-bit port state, a membership map, and a default-tag register. An isolation mode turns the switch into a router front end. In that mode every non-CPU port can reach only the CPU port, and the CPU port can reach every other port that is forwarding. The CPU port is chosen from two legal candidates, and any other selection falls back to a fixed default.

Top module: `vlan_filter`

## Requirements
- R1: After reset every port state, membership map and default tag is 0, so rsp_valid is 0 and any request returns an egress mask of 0 with VID 0 and priority 0.
- R2: cfg_sel 0 writes the control register of port cfg_port. Bits [1:0] are the port state: 0 disabled, 1 and 2 not forwarding, 3 forwarding. An egress bit can be 1 only if that destination's state is 3.
- R3: If the ingress port's state is not 3, or req_port is not below the port count, the egress mask is 0.
- R4: cfg_sel 1 writes the membership map of port cfg_port from bits [NUM_PORTS-1:0], one bit per destination port, with the port's own bit forced to 0. Outside isolation mode the egress mask is req_cand AND the ingress map AND the forwarding set, and the ingress port's bit is never set.
- R5: cfg_sel 2 writes the default-tag register of port cfg_port: bits [11:0] are the VID and bits [15:14] the priority. The response carries the ingress port's values, or 0 when req_port is out of range.
- R6: The CPU port is cpu_sel when cpu_sel is 4 or 5, and port 5 otherwise.
- R7: With iso_mode 1 the maps are ignored. A non-CPU ingress port may reach only the CPU port. The CPU port may reach every forwarding port except itself. Both results are still gated by req_cand and by the ingress state.
- R8: rsp_valid is 1 exactly in the cycle after a cycle with req_valid 1. When rsp_valid is 0, rsp_mask is 0.
- R9: A request presented in the same cycle as a configuration write is judged with the configuration as it was before that write. Writes with cfg_sel 3, or with cfg_port not below the port count, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | 3 | Port whose register is written |
| cfg_sel | input | 2 | Register select: 0 control, 1 map, 2 default tag, 3 reserved |
| cfg_wdata | input | 16 | Write data |
| iso_mode | input | 1 | Router isolation mode |
| cpu_sel | input | 3 | Requested CPU port (4 or 5 legal) |
| req_valid | input | 1 | Filter request valid |
| req_port | input | 3 | Ingress port of the request |
| req_cand | input | 6 | Candidate destination mask from lookup |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_mask | output | 6 | Permitted egress mask |
| rsp_vid | output | 12 | Default VID of the ingress port |
| rsp_pri | output | 2 | Default priority of the ingress port |

## Verification
A configuration write and a filter request can land in the same cycle, and the write may target the very port or register the request depends on. The bench provokes this both in directed cases and in random traffic: for example, it disables an ingress port, or rewrites its map, in the cycle of its own request. The bench model computes the expected response from the configuration before the write and applies the write to its model only afterwards. The next request must then reflect the new setting.

// File: rtl/vlan_filter_pkg.sv
// Package: shared register encodings and field positions of the VLAN
// egress filter. Assumes a 16-bit configuration register width.
package vlan_filter_pkg;

    localparam int REG_W    = 16;
    localparam int ST_W     = 2;
    localparam int VID_W    = 12;
    localparam int PRI_W    = 2;
    localparam int PRI_LSB  = 14;

    // Port state code that allows a port to send and receive frames.
    localparam logic [ST_W-1:0] ST_FORWARD = 2'b11;

    // Register select codes on cfg_sel.
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MAP  = 2'd1,
        SEL_TAG  = 2'd2,
        SEL_RSVD = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/vlan_cfg_regs.sv
// Module: per-port configuration storage (state, membership map, default
// tag). One register set per port is built by a generate loop. Assumes
// NUM_PORTS <= REG_W. Writes to a port index outside the port count, or
// with the reserved select code, touch nothing. A map write always drops
// the port's own bit.
module vlan_cfg_regs
    import vlan_filter_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    localparam int PIDX_W   = $clog2(NUM_PORTS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [PIDX_W-1:0]                   cfg_port,
    input  logic [1:0]                          cfg_sel,
    input  logic [REG_W-1:0]                    cfg_wdata,
    output logic [NUM_PORTS-1:0][NUM_PORTS-1:0] map_q,
    output logic [NUM_PORTS-1:0][VID_W-1:0]     vid_q,
    output logic [NUM_PORTS-1:0][PRI_W-1:0]     pri_q,
    output logic [NUM_PORTS-1:0]                fwd_q
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [ST_W-1:0]      state_r;
        logic [NUM_PORTS-1:0] self_bit;
        logic                 hit;

        assign self_bit = NUM_PORTS'(1) << p;
        assign hit      = cfg_we && (int'(cfg_port) == p);

        // Update this port's registers on a write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_r  <= '0;
                map_q[p] <= '0;
                vid_q[p] <= '0;
                pri_q[p] <= '0;
            end else if (hit) begin
                case (cfg_sel)
                    SEL_CTRL: state_r  <= cfg_wdata[ST_W-1:0];
                    SEL_MAP:  map_q[p] <= cfg_wdata[NUM_PORTS-1:0] & ~self_bit;
                    SEL_TAG: begin
                        vid_q[p] <= cfg_wdata[VID_W-1:0];
                        pri_q[p] <= cfg_wdata[PRI_LSB +: PRI_W];
                    end
                    default: ;
                endcase
            end
        end

        assign fwd_q[p] = (state_r == ST_FORWARD);
    end

endmodule

// File: rtl/vlan_cpu_sel.sv
// Module: resolves the CPU port from the requested selection. Only the
// two legal candidates are accepted; anything else falls back to a fixed
// default. Produces both the index and a one-hot mask.
module vlan_cpu_sel #(
    parameter int NUM_PORTS = 6,
    parameter int CPU_A     = 4,
    parameter int CPU_B     = 5,
    parameter int CPU_DFLT  = 5,
    localparam int PIDX_W   = $clog2(NUM_PORTS)
) (
    input  logic [PIDX_W-1:0]    cpu_sel,
    output logic [PIDX_W-1:0]    cpu_idx,
    output logic [NUM_PORTS-1:0] cpu_onehot
);

    // Pick the requested port when legal, otherwise the default.
    always_comb begin
        if (int'(cpu_sel) == CPU_A || int'(cpu_sel) == CPU_B)
            cpu_idx = cpu_sel;
        else
            cpu_idx = PIDX_W'(CPU_DFLT);
        cpu_onehot = NUM_PORTS'(1) << cpu_idx;
    end

endmodule

// File: rtl/vlan_egress_calc.sv
// Module: combinational egress decision. Selects the effective membership
// map (stored map, or the isolation rule), gates it with the candidate
// mask and the forwarding set, removes the ingress bit and blanks the
// result when the ingress port is out of range or not forwarding.
module vlan_egress_calc
    import vlan_filter_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    localparam int PIDX_W   = $clog2(NUM_PORTS)
) (
    input  logic [PIDX_W-1:0]                   req_port,
    input  logic [NUM_PORTS-1:0]                req_cand,
    input  logic                                iso_mode,
    input  logic [PIDX_W-1:0]                   cpu_idx,
    input  logic [NUM_PORTS-1:0]                cpu_onehot,
    input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] map_q,
    input  logic [NUM_PORTS-1:0][VID_W-1:0]     vid_q,
    input  logic [NUM_PORTS-1:0][PRI_W-1:0]     pri_q,
    input  logic [NUM_PORTS-1:0]                fwd_q,
    output logic [NUM_PORTS-1:0]                egress,
    output logic [VID_W-1:0]                    vid,
    output logic [PRI_W-1:0]                    pri
);

    logic                 in_range;
    logic [PIDX_W-1:0]    idx;
    logic [NUM_PORTS-1:0] self_oh;
    logic [NUM_PORTS-1:0] map_eff;

    // Clamp the ingress index so no array is read out of range.
    always_comb begin
        in_range = (int'(req_port) < NUM_PORTS);
        idx      = in_range ? req_port : '0;
        self_oh  = NUM_PORTS'(1) << idx;
    end

    // Choose the membership rule: stored map or isolation rule.
    always_comb begin
        if (iso_mode)
            map_eff = (idx == cpu_idx) ? '1 : cpu_onehot;
        else
            map_eff = map_q[idx];
    end

    // Combine all gates into the permitted mask and the default tag.
    always_comb begin
        if (in_range && fwd_q[idx])
            egress = req_cand & map_eff & fwd_q & ~self_oh;
        else
            egress = '0;
        vid = in_range ? vid_q[idx] : '0;
        pri = in_range ? pri_q[idx] : '0;
    end

endmodule

// File: rtl/vlan_filter.sv
// Module: top of the port-based VLAN egress filter. Holds per-port
// configuration, resolves the CPU port and registers the egress decision
// one cycle after each valid request. A request in the same cycle as a
// configuration write sees the configuration before that write.
module vlan_filter
    import vlan_filter_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    localparam int PIDX_W   = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [PIDX_W-1:0]    cfg_port,
    input  logic [1:0]           cfg_sel,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic                 iso_mode,
    input  logic [PIDX_W-1:0]    cpu_sel,
    input  logic                 req_valid,
    input  logic [PIDX_W-1:0]    req_port,
    input  logic [NUM_PORTS-1:0] req_cand,
    output logic                 rsp_valid,
    output logic [NUM_PORTS-1:0] rsp_mask,
    output logic [VID_W-1:0]     rsp_vid,
    output logic [PRI_W-1:0]     rsp_pri
);

    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] map_q;
    logic [NUM_PORTS-1:0][VID_W-1:0]     vid_q;
    logic [NUM_PORTS-1:0][PRI_W-1:0]     pri_q;
    logic [NUM_PORTS-1:0]                fwd_q;
    logic [PIDX_W-1:0]                   cpu_idx;
    logic [NUM_PORTS-1:0]                cpu_onehot;
    logic [NUM_PORTS-1:0]                egress_c;
    logic [VID_W-1:0]                    vid_c;
    logic [PRI_W-1:0]                    pri_c;

    vlan_cfg_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_port  (cfg_port),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .map_q     (map_q),
        .vid_q     (vid_q),
        .pri_q     (pri_q),
        .fwd_q     (fwd_q)
    );

    vlan_cpu_sel #(.NUM_PORTS(NUM_PORTS)) u_cpu (
        .cpu_sel    (cpu_sel),
        .cpu_idx    (cpu_idx),
        .cpu_onehot (cpu_onehot)
    );

    vlan_egress_calc #(.NUM_PORTS(NUM_PORTS)) u_calc (
        .req_port   (req_port),
        .req_cand   (req_cand),
        .iso_mode   (iso_mode),
        .cpu_idx    (cpu_idx),
        .cpu_onehot (cpu_onehot),
        .map_q      (map_q),
        .vid_q      (vid_q),
        .pri_q      (pri_q),
        .fwd_q      (fwd_q),
        .egress     (egress_c),
        .vid        (vid_c),
        .pri        (pri_c)
    );

    // Register the decision; outputs are cleared when no request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_mask  <= '0;
            rsp_vid   <= '0;
            rsp_pri   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_mask  <= req_valid ? egress_c : '0;
            rsp_vid   <= req_valid ? vid_c : '0;
            rsp_pri   <= req_valid ? pri_c : '0;
        end
    end

endmodule

// File: rtl/vlan_filter_chk.sv
// Module: port-level checker for vlan_filter, attached by bind. It
// watches only the top-level ports and derives the CPU port on its own.
module vlan_filter_chk #(
    parameter int NUM_PORTS = 6,
    localparam int PIDX_W   = $clog2(NUM_PORTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iso_mode,
    input logic [PIDX_W-1:0]    cpu_sel,
    input logic                 req_valid,
    input logic [PIDX_W-1:0]    req_port,
    input logic [NUM_PORTS-1:0] req_cand,
    input logic                 rsp_valid,
    input logic [NUM_PORTS-1:0] rsp_mask
);

    logic [NUM_PORTS-1:0] cpu_bit_c;
    logic [PIDX_W-1:0]    cpu_num_c;
    logic                 port_ok_c;

    // Independent view of the CPU port and the ingress range check.
    always_comb begin
        cpu_num_c = (cpu_sel == PIDX_W'(4)) ? PIDX_W'(4) : PIDX_W'(5);
        cpu_bit_c = NUM_PORTS'(1) << cpu_num_c;
        port_ok_c = (int'(req_port) < NUM_PORTS);
    end

    p_resp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_resp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_mask == '0));

    p_no_reflect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && port_ok_c) |=>
            ((rsp_mask & (NUM_PORTS'(1) << $past(req_port))) == '0));

    p_within_cand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((rsp_mask & ~$past(req_cand)) == '0));

    p_iso_cpu_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && iso_mode && port_ok_c && req_port != cpu_num_c) |=>
            ((rsp_mask & ~$past(cpu_bit_c)) == '0));

endmodule

bind vlan_filter vlan_filter_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .iso_mode  (iso_mode),
    .cpu_sel   (cpu_sel),
    .req_valid (req_valid),
    .req_port  (req_port),
    .req_cand  (req_cand),
    .rsp_valid (rsp_valid),
    .rsp_mask  (rsp_mask)
);

// File: tb/vlan_filter_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked
// against a behavioural model of the requirements.
module vlan_filter_tb_top;

    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_port = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        iso_mode = 1'b0;
    logic [2:0]  cpu_sel = 3'd5;
    logic        req_valid = 1'b0;
    logic [2:0]  req_port = '0;
    logic [N-1:0] req_cand = '0;
    logic        rsp_valid;
    logic [N-1:0] rsp_mask;
    logic [11:0] rsp_vid;
    logic [1:0]  rsp_pri;

    int vectors = 0;
    int miscompares = 0;

    // Model state.
    logic [1:0]   m_st  [N];
    logic [N-1:0] m_map [N];
    logic [11:0]  m_vid [N];
    logic [1:0]   m_pri [N];

    always #4 clk = ~clk;

    vlan_filter #(.NUM_PORTS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .iso_mode(iso_mode),
        .cpu_sel(cpu_sel), .req_valid(req_valid), .req_port(req_port),
        .req_cand(req_cand), .rsp_valid(rsp_valid), .rsp_mask(rsp_mask),
        .rsp_vid(rsp_vid), .rsp_pri(rsp_pri)
    );

    function automatic int cpu_of(logic [2:0] s);
        return (s == 3'd4 || s == 3'd5) ? int'(s) : 5;
    endfunction

    function automatic logic [N-1:0] exp_mask(int p, logic [N-1:0] cand);
        logic [N-1:0] r;
        int c;
        r = '0;
        if (p >= N) return r;
        if (m_st[p] != 2'b11) return r;
        c = cpu_of(cpu_sel);
        for (int d = 0; d < N; d++) begin
            bit allow;
            if (iso_mode) allow = (p == c) ? 1'b1 : (d == c);
            else          allow = m_map[p][d];
            if (d != p && cand[d] && allow && m_st[d] == 2'b11) r[d] = 1'b1;
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int p = 0; p < N; p++) begin
            m_st[p] = '0; m_map[p] = '0; m_vid[p] = '0; m_pri[p] = '0;
        end
    endtask

    task automatic model_write(int p, int sel, logic [15:0] d);
        if (p >= N) return;
        case (sel)
            0: m_st[p] = d[1:0];
            1: begin m_map[p] = d[N-1:0]; m_map[p][p] = 1'b0; end
            2: begin m_vid[p] = d[11:0]; m_pri[p] = d[15:14]; end
            default: ;
        endcase
    endtask

    task automatic fail(string tag, string what, int act, int expv);
        miscompares++;
        $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    endtask

    // One cycle: drive at the falling edge, check after the next falling edge.
    task automatic step(bit we, int cp, int sel, logic [15:0] d,
                        bit rv, int rp, logic [N-1:0] cand, string tag);
        logic [N-1:0] em;
        logic [11:0]  ev;
        logic [1:0]   epr;
        cfg_we = we; cfg_port = 3'(cp); cfg_sel = 2'(sel); cfg_wdata = d;
        req_valid = rv; req_port = 3'(rp); req_cand = cand;
        em  = rv ? exp_mask(rp, cand) : '0;
        ev  = (rv && rp < N) ? m_vid[rp] : '0;
        epr = (rv && rp < N) ? m_pri[rp] : '0;
        if (we) model_write(cp, sel, d);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        vectors++;
        if (rsp_valid !== rv) fail(tag, "rsp_valid", int'(rsp_valid), int'(rv));
        if (rsp_mask !== em)  fail(tag, "rsp_mask", int'(rsp_mask), int'(em));
        if (rv && rsp_vid !== ev)  fail(tag, "rsp_vid", int'(rsp_vid), int'(ev));
        if (rv && rsp_pri !== epr) fail(tag, "rsp_pri", int'(rsp_pri), int'(epr));
    endtask

    task automatic req(int rp, logic [N-1:0] cand, string tag);
        step(1'b0, 0, 0, 16'h0, 1'b1, rp, cand, tag);
    endtask

    task automatic wr(int cp, int sel, logic [15:0] d, string tag);
        step(1'b1, cp, sel, d, 1'b0, 0, '0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs idle after reset, and a request finds everything disabled.
        vectors++;
        if (rsp_valid !== 1'b0 || rsp_mask !== '0)
            fail("R1", "reset outputs", int'({rsp_valid, rsp_mask}), 0);
        req(0, 6'h3F, "R1");
        req(3, 6'h3F, "R1");

        // R2/R4: all forwarding, full maps (own bit dropped by the block).
        for (int p = 0; p < N; p++) wr(p, 0, 16'h0003, "R2");
        for (int p = 0; p < N; p++) wr(p, 1, 16'h003F, "R4");
        req(1, 6'h3F, "R4");
        req(0, 6'h3F, "R4");
        req(2, 6'h15, "R4");
        // R4: sparse map on port 3.
        wr(3, 1, 16'h0009, "R4");
        req(3, 6'h3F, "R4");
        // R2: states 1 and 2 are not forwarding.
        wr(2, 0, 16'h0002, "R2");
        wr(4, 0, 16'h0001, "R2");
        req(1, 6'h3F, "R2");
        // R3: ingress not forwarding, and ingress out of range.
        req(2, 6'h3F, "R3");
        req(6, 6'h3F, "R3");
        req(7, 6'h3F, "R3");
        // R5: default tag.
        wr(1, 2, 16'hC123, "R5");
        wr(5, 2, 16'h4ABC, "R5");
        req(1, 6'h3F, "R5");
        req(5, 6'h00, "R5");
        // R6/R7: isolation with legal and fallback CPU selections.
        wr(2, 0, 16'h0003, "R7");
        wr(4, 0, 16'h0003, "R7");
        iso_mode = 1'b1; cpu_sel = 3'd4;
        req(1, 6'h3F, "R6");
        req(4, 6'h3F, "R7");
        cpu_sel = 3'd7;
        req(1, 6'h3F, "R6");
        req(5, 6'h3F, "R7");
        cpu_sel = 3'd0;
        req(5, 6'h0C, "R6");
        iso_mode = 1'b0; cpu_sel = 3'd5;
        // R8: idle cycles produce no response.
        step(1'b0, 0, 0, 16'h0, 1'b0, 0, 6'h3F, "R8");
        // R9: write and request in the same cycle use the old configuration.
        step(1'b1, 1, 0, 16'h0000, 1'b1, 1, 6'h3F, "R9");
        req(1, 6'h3F, "R9");
        step(1'b1, 0, 1, 16'h0002, 1'b1, 0, 6'h3F, "R9");
        req(0, 6'h3F, "R9");
        // R9: reserved select and out-of-range port writes are dropped.
        wr(0, 3, 16'h0000, "R9");
        wr(6, 0, 16'h0000, "R9");
        wr(7, 1, 16'h0000, "R9");
        req(0, 6'h3F, "R9");

        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            bit we, rv;
            int sel, cp, rp;
            logic [15:0] d;
            we  = ($urandom % 10) < 3;
            rv  = ($urandom % 10) < 8;
            sel = $urandom % 4;
            cp  = $urandom % 8;
            rp  = $urandom % 8;
            d   = 16'($urandom);
            if (sel == 0 && ($urandom % 4) != 0) d[1:0] = 2'b11;
            if (($urandom % 50) == 0) iso_mode = ~iso_mode;
            if (($urandom % 40) == 0) cpu_sel = 3'($urandom);
            step(we, cp, sel, d, rv, rp, 6'($urandom), "R4");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule